// File: doc/BRIEF.md
# Receive Byte Store with Count Acknowledge

This block holds the bytes that a high-speed serial receiver delivers and lets software take them in bulk. Bytes go in one per cycle from the receiver into a 1024-byte circular store. Software does not pop bytes one at a time. It reads a 32-bit window that shows the stored bytes in place, starting at the oldest unread byte. When it is done, it writes back how many bytes it used, and the block frees exactly that many.

Word 0 of the window returns a status word that carries the fill count. Window words 1 to 255 return data. Each data word packs four consecutive stored bytes, least significant byte first, counted from the current read position and wrapping around the store. That gives at most 1020 bytes per pass. A data request is raised when the fill reaches a threshold picked by a 3-bit level code. A second request is raised when an external character-timeout signal fires while data is waiting. One interrupt enable gates both requests.

Top module: `rxq_ack_buffer`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `fill_count` is 0, `rx_drop`, `rx_data_req` and `rx_timeout_req` are 0, and `win_rdata` is 0.
- R2: A cycle with `rx_valid` high and a fill below 1023 stores `rx_byte` and raises the fill by one at that clock edge.
- R3: The usable capacity is 1023 bytes. A byte offered at a fill of 1023 is dropped: the fill stays unchanged, the stored data stays unchanged, and `rx_drop` is high for the one cycle after that edge.
- R4: A read with `win_rd` high and `win_addr` = w, where w is 1 to 255, returns in `win_rdata` after the next edge the stored bytes at positions 4(w-1)+j past the read position, for j = 0..3. Byte j sits in bits [8j+7:8j]. Positions wrap modulo 1024.
- R5: A read at `win_addr` 0 returns the status word. Fill bits 7:0 are at [31:24], fill bits 9:8 are at [7:6], and every other bit is 0.
- R6: A cycle with `ack_we` high and `ack_n` = N, where N is at most the fill, lowers the fill by N. It also advances the read position by N, so window word 1 then begins with the byte N places later.
- R7: An acknowledge count larger than the fill releases only the bytes present, leaving the fill at 0.
- R8: An acknowledge and a push in the same cycle both take effect. The push is accepted only if the fill before that edge was below 1023.
- R9: `rx_data_req` is registered. One edge after the fill or the settings change, it equals `rx_irq_en` AND (fill >= 2^(`rx_trig_lvl`+2)). So code 0 means 4 bytes and code 7 means 512 bytes.
- R10: With `rx_irq_en` low, neither request is raised at any fill or level code.
- R11: `rx_timeout_req` is registered. One edge later, it equals `rx_irq_en` AND `char_timeout` AND (fill != 0).
- R12: `fill_count` always equals the number of stored, unacknowledged bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receiver offers a byte this cycle |
| rx_byte | input | 8 | Byte from the receiver |
| win_rd | input | 1 | Window read strobe |
| win_addr | input | 8 | Window longword index; 0 selects status |
| win_rdata | output | 32 | Window read data, valid one cycle after the strobe |
| ack_we | input | 1 | Acknowledge strobe |
| ack_n | input | 10 | Number of bytes consumed |
| rx_irq_en | input | 1 | Enable for both requests |
| rx_trig_lvl | input | 3 | Threshold code n, meaning 2^(n+2) bytes |
| char_timeout | input | 1 | Character timeout indication from an external timer |
| fill_count | output | 10 | Current number of stored bytes |
| rx_drop | output | 1 | Pulse: a byte was lost because the store was full |
| rx_data_req | output | 1 | Fill has reached the threshold |
| rx_timeout_req | output | 1 | Timeout with data waiting |

## Verification
Pushes and acknowledges reach `fill_count` and `rx_drop` at the edge that samples them. Window reads show up on `win_rdata` at the edge after the strobe. Both requests appear one edge later still, because they are registered from the already-registered fill. The bench drives every input on a falling edge and reads results on the following falling edge; for requests it waits one extra cycle. It keeps its own arithmetic model of the byte stream (value = 37k+11 for stream index k) and of the fill. Against that model it sweeps all eight level codes at several fills, reads every window word that holds data at aligned, unaligned and wrapped read positions, and exercises overfill and oversize acknowledges.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int STATUS_W = 32;
    localparam int FILL_W   = 10;

    // Status word: low fill byte in the top byte, fill bits 9:8 in bits 7:6
    function automatic logic [STATUS_W-1:0] rxq_status(input logic [FILL_W-1:0] fill);
        logic [STATUS_W-1:0] s;
        s        = '0;
        s[31:24] = fill[7:0];
        s[7:6]   = fill[9:8];
        return s;
    endfunction

endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              ack_we,
    input  logic [ADDR_W-1:0] ack_n,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] count,
    output logic              push_ok,
    output logic              drop
);
    localparam logic [ADDR_W-1:0] FULL = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] wr;
        logic [ADDR_W-1:0] rd;
        logic [ADDR_W-1:0] cnt;
        logic              drop;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic [ADDR_W-1:0] rel_d;
    logic              ok_d;

    always_comb begin
        rel_d = '0;
        if (ack_we) begin
            rel_d = (ack_n > st_q.cnt) ? st_q.cnt : ack_n;
        end
        ok_d        = push && (st_q.cnt != FULL);
        st_d        = st_q;
        st_d.wr     = st_q.wr + ADDR_W'(ok_d);
        st_d.rd     = st_q.rd + rel_d;
        st_d.cnt    = st_q.cnt - rel_d + ADDR_W'(ok_d);
        st_d.drop   = push && !ok_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr  = st_q.wr;
    assign rd_ptr  = st_q.rd;
    assign count   = st_q.cnt;
    assign push_ok = ok_d;
    assign drop    = st_q.drop;

    // R12: write and read positions stay exactly fill apart
    p_ptr_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr - st_q.rd) == st_q.cnt);

    // R2: an accepted push alone raises the fill by one
    p_push_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !ack_we && st_q.cnt != FULL) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R3: a push into a full store is dropped and flagged
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !ack_we && st_q.cnt == FULL) |=> (st_q.drop && st_q.cnt == FULL));

    // R7: an oversize acknowledge empties the store
    p_ack_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !push && ack_n >= st_q.cnt) |=> (st_q.cnt == '0));

endmodule

// File: rtl/rxq_mem.sv
module rxq_mem #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              rd_en,
    input  logic [ADDR_W-3:0] word_idx,
    input  logic [ADDR_W-1:0] rd_base,
    input  logic [31:0]       status_word,
    output logic [31:0]       rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int WW    = ADDR_W - 2;
    localparam int LANES = 4;
    localparam logic [WW-1:0] ONE_W = WW'(1);

    typedef struct packed {
        logic [31:0] data;
    } rd_st_t;

    logic [7:0] store [DEPTH];
    logic [7:0] lane_byte [LANES];
    logic [ADDR_W-1:0] word_off;
    rd_st_t st_d, st_q;

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign word_off = {word_idx - ONE_W, 2'b00};

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        assign lane_addr       = rd_base + word_off + ADDR_W'(lane);
        assign lane_byte[lane] = store[lane_addr];
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            if (word_idx == '0) begin
                st_d.data = status_word;
            end else begin
                st_d.data = {lane_byte[3], lane_byte[2], lane_byte[1], lane_byte[0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.data;

    // R5: a status read leaves every non-fill bit at zero
    p_status_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(word_idx) == '0) |-> (rdata[23:8] == '0 && rdata[5:0] == '0));

    // R4: read data only changes after a read strobe
    p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));

endmodule

// File: rtl/rxq_trig.sv
module rxq_trig #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] count,
    input  logic              irq_en,
    input  logic [2:0]        lvl,
    input  logic              char_timeout,
    output logic              data_req,
    output logic              to_req
);
    localparam int CW = ADDR_W + 1;

    typedef struct packed {
        logic data;
        logic tmo;
    } req_st_t;

    req_st_t st_d, st_q;
    logic [CW-1:0] thresh;
    logic [3:0]    shamt;

    assign shamt  = {1'b0, lvl} + 4'd2;
    assign thresh = CW'(1) << shamt;

    always_comb begin
        st_d.data = irq_en && ({1'b0, count} >= thresh);
        st_d.tmo  = irq_en && char_timeout && (count != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_req = st_q.data;
    assign to_req   = st_q.tmo;

    // R10: no request without the enable
    p_req_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_req || to_req) |-> $past(irq_en));

    // R11: a timeout request implies data was waiting
    p_tmo_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        to_req |-> ($past(count) != '0 && $past(char_timeout)));

    // R9: a data request implies at least four bytes were held
    p_req_min_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_req |-> ($past(count) >= ADDR_W'(4)));

endmodule

// File: rtl/rxq_ack_buffer.sv
module rxq_ack_buffer #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              win_rd,
    input  logic [ADDR_W-3:0] win_addr,
    output logic [31:0]       win_rdata,
    input  logic              ack_we,
    input  logic [ADDR_W-1:0] ack_n,
    input  logic              rx_irq_en,
    input  logic [2:0]        rx_trig_lvl,
    input  logic              char_timeout,
    output logic [ADDR_W-1:0] fill_count,
    output logic              rx_drop,
    output logic              rx_data_req,
    output logic              rx_timeout_req
);
    import rxq_pkg::*;

    logic [ADDR_W-1:0] wr_ptr, rd_ptr, count;
    logic              push_ok;
    logic [31:0]       status_word;

    rxq_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rx_valid),
        .ack_we  (ack_we),
        .ack_n   (ack_n),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .count   (count),
        .push_ok (push_ok),
        .drop    (rx_drop)
    );

    assign status_word = rxq_status(FILL_W'(count));

    rxq_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (push_ok),
        .waddr       (wr_ptr),
        .wdata       (rx_byte),
        .rd_en       (win_rd),
        .word_idx    (win_addr),
        .rd_base     (rd_ptr),
        .status_word (status_word),
        .rdata       (win_rdata)
    );

    rxq_trig #(.ADDR_W(ADDR_W)) u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .count        (count),
        .irq_en       (rx_irq_en),
        .lvl          (rx_trig_lvl),
        .char_timeout (char_timeout),
        .data_req     (rx_data_req),
        .to_req       (rx_timeout_req)
    );

    assign fill_count = count;

    // R6: an in-range acknowledge without a push lowers the fill by exactly N
    p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !rx_valid && ack_n <= fill_count) |=> (fill_count == $past(fill_count) - $past(ack_n)));

endmodule

// File: tb/rxq_ack_buffer_test.sv
module rxq_ack_buffer_test;
    localparam int FULLN = 1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic win_rd = 1'b0;
    logic [7:0] win_addr = '0;
    logic [31:0] win_rdata;
    logic ack_we = 1'b0;
    logic [9:0] ack_n = '0;
    logic rx_irq_en = 1'b0;
    logic [2:0] rx_trig_lvl = '0;
    logic char_timeout = 1'b0;
    logic [9:0] fill_count;
    logic rx_drop, rx_data_req, rx_timeout_req;

    int n_chk = 0;
    int n_fail = 0;
    int cnt = 0;
    int consumed = 0;
    int produced = 0;
    bit last_drop = 0;

    always #5 clk = ~clk;

    rxq_ack_buffer uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .win_rd(win_rd), .win_addr(win_addr), .win_rdata(win_rdata),
        .ack_we(ack_we), .ack_n(ack_n), .rx_irq_en(rx_irq_en),
        .rx_trig_lvl(rx_trig_lvl), .char_timeout(char_timeout),
        .fill_count(fill_count), .rx_drop(rx_drop),
        .rx_data_req(rx_data_req), .rx_timeout_req(rx_timeout_req)
    );

    function automatic logic [7:0] val(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = val(produced);
            if (cnt < FULLN) begin
                cnt++;
                produced++;
                last_drop = 0;
            end else begin
                last_drop = 1;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic ack(input int n);
        int rel;
        @(negedge clk);
        ack_we = 1'b1;
        ack_n  = 10'(n);
        rel = (n > cnt) ? cnt : n;
        cnt -= rel;
        consumed += rel;
        @(negedge clk);
        ack_we = 1'b0;
    endtask

    task automatic push_ack(input int n);
        int rel;
        @(negedge clk);
        ack_we   = 1'b1;
        ack_n    = 10'(n);
        rx_valid = 1'b1;
        rx_byte  = val(produced);
        rel = (n > cnt) ? cnt : n;
        if (cnt < FULLN) begin
            produced++;
            cnt = cnt - rel + 1;
        end else begin
            cnt = cnt - rel;
        end
        consumed += rel;
        @(negedge clk);
        ack_we   = 1'b0;
        rx_valid = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        win_rd   = 1'b1;
        win_addr = 8'(addr);
        @(negedge clk);
        win_rd = 1'b0;
        data = win_rdata;
    endtask

    task automatic check_window(input string tag);
        logic [31:0] d;
        for (int w = 1; w < 256; w++) begin
            if (4 * (w - 1) < cnt) begin
                rd(w, d);
                for (int j = 0; j < 4; j++) begin
                    int off;
                    off = 4 * (w - 1) + j;
                    if (off < cnt)
                        chk(d[8*j +: 8] == val(consumed + off), tag, d[8*j +: 8], val(consumed + off));
                end
            end
        end
    endtask

    task automatic trig_sweep();
        for (int code = 0; code < 8; code++) begin
            @(negedge clk);
            rx_trig_lvl = 3'(code);
            settle();
            chk(rx_data_req == (cnt >= (1 << (code + 2))), "R9 trigger level", rx_data_req, cnt >= (1 << (code + 2)));
        end
        @(negedge clk);
        rx_irq_en = 1'b0;
        settle();
        chk(rx_data_req == 1'b0, "R10 disabled request", rx_data_req, 0);
        @(negedge clk);
        rx_irq_en = 1'b1;
        rx_trig_lvl = 3'd0;
        settle();
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        chk(fill_count == 0, "R1 reset fill", fill_count, 0);
        chk(!rx_drop && !rx_data_req && !rx_timeout_req, "R1 reset flags", {rx_drop, rx_data_req, rx_timeout_req}, 0);
        chk(win_rdata == 0, "R1 reset rdata", win_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fill_count == 0 && !rx_data_req, "R1 after release", fill_count, 0);
        rx_irq_en = 1'b1;
        rx_trig_lvl = 3'd0;

        push_n(3);
        chk(fill_count == 10'(cnt), "R2 R12 fill after push", fill_count, cnt);
        settle();
        chk(rx_data_req == 1'b0, "R9 below level 4", rx_data_req, 0);
        push_n(1);
        chk(fill_count == 4, "R2 fill 4", fill_count, 4);
        settle();
        chk(rx_data_req == 1'b1, "R9 at level 4", rx_data_req, 1);

        push_n(296);
        rd(0, d);
        chk(d == {8'(cnt), 16'h0, 2'(cnt >> 8), 6'h0}, "R5 status word", d, {8'(cnt), 16'h0, 2'(cnt >> 8), 6'h0});
        trig_sweep();
        check_window("R4 aligned window");

        ack(5);
        chk(fill_count == 10'(cnt), "R6 ack 5", fill_count, cnt);
        ack(3);
        chk(fill_count == 10'(cnt), "R6 ack 3", fill_count, cnt);
        check_window("R4 R6 unaligned window");

        push_ack(10);
        chk(fill_count == 10'(cnt), "R8 push with ack", fill_count, cnt);
        check_window("R8 window after push with ack");
        trig_sweep();

        @(negedge clk);
        char_timeout = 1'b1;
        settle();
        chk(rx_timeout_req == 1'b1, "R11 timeout with data", rx_timeout_req, 1);
        @(negedge clk);
        rx_irq_en = 1'b0;
        settle();
        chk(rx_timeout_req == 1'b0, "R10 R11 timeout disabled", rx_timeout_req, 0);
        @(negedge clk);
        rx_irq_en = 1'b1;

        ack(1023);
        chk(fill_count == 0, "R7 oversize ack clamps", fill_count, 0);
        settle();
        chk(rx_timeout_req == 1'b0, "R11 timeout when empty", rx_timeout_req, 0);
        @(negedge clk);
        char_timeout = 1'b0;

        push_n(1030);
        chk(fill_count == 10'(FULLN), "R3 fill saturates", fill_count, FULLN);
        chk(rx_drop == last_drop && last_drop, "R3 drop pulse", rx_drop, 1);
        settle();
        chk(rx_drop == 1'b0, "R3 drop clears", rx_drop, 0);
        rd(0, d);
        chk(d == {8'hFF, 16'h0, 2'b11, 6'h0}, "R5 status at full", d, {8'hFF, 16'h0, 2'b11, 6'h0});
        trig_sweep();
        check_window("R3 R4 wrapped window");

        ack(1020);
        chk(fill_count == 10'(cnt), "R6 ack 1020", fill_count, cnt);
        push_n(1025);
        push_ack(1);
        chk(fill_count == 10'(cnt), "R8 push at full with ack", fill_count, cnt);
        check_window("R3 R8 data kept after dropped push");

        report();
    end
endmodule